// File: doc/BRIEF.md
# Security Violation Interrupt Aggregator

This block gathers single-cycle violation pulses from a parameterised set of sources and turns them into one level-sensitive interrupt for the secure processor. Each source has a sticky status flag. A pulse sets the flag only while the source's enable bit is 1. The flag stays set until software writes 1 to the matching clear bit. The interrupt is the OR of all flags. A global security-enable input gates it in hardware, so no interrupt can leave the block while security is off. Flags still record violations while security is off.

Software reaches the block through a small word-addressed register port. The port has three registers: an enable register, a read-only status register and a write-one-to-clear register. Every enable bit is 1 after reset, so all sources are armed from the start. Software masks the sources it does not want.

Top module: `secviol_agg`

## Requirements
- R1: After synchronous reset, the enable register reads with bits 0..NUM_SRC-1 all 1, the status register reads 0 and irq_o is 0.
- R2: A pulse on ev_i[i] while enable bit i is 1 sets status bit i. The bit reads as 1 from the cycle after the clock edge that sampled the pulse.
- R3: A pulse on a source whose enable bit is 0 leaves its status bit at 0.
- R4: A set status bit stays set until a write of 1 to the same bit position at the clear register. Bits written as 0 at the clear register have no effect.
- R5: When an enabled pulse and a clear write for the same bit fall in the same cycle, the bit ends up set.
- R6: irq_o is 1 exactly when sec_en_i is 1 and at least one status bit is set. It stays 1 until the last set bit is cleared.
- R7: While sec_en_i is 0, irq_o is 0 even with status bits set. Enabled pulses still set status bits. irq_o rises combinationally when sec_en_i returns to 1 with a bit pending.
- R8: Register map by word address: 0 is the enable register (read/write), 1 is the status register (read-only, writes ignored), 2 is the clear register (write-one-to-clear, reads 0). Every other address reads 0 and ignores writes. Read data is 0 when bus_sel_i is 0.
- R9: Bit positions at or above NUM_SRC read as 0 in every register. Writes to those positions have no effect.
- R10: An enable write acts on pulses sampled at later clock edges. A pulse sampled at the same edge as the enable write is filtered by the previous enable value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_en_i | input | 1 | Global security enable; 0 blocks the interrupt |
| ev_i | input | NUM_SRC | Violation pulses, one bit per source |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Level interrupt toward the secure processor |

## Verification
The bench builds the block with NUM_SRC = 20 and ADDR_W = 3. Twenty sources leave twelve unimplemented bit positions in every register word, so the bench can check that upper bits read as zero and that writes to them are dropped. The three-bit address reaches the unused words 3 and 5, where reads must return zero and writes must change nothing. The scenarios cover a pulse arriving at the same edge as a clear write, and a pulse arriving at the same edge as an enable write in both directions. They also cover toggling the security enable while a flag is pending.

// File: rtl/viol_agg_pkg.sv
// Package: shared constants, register selector type and mask helper for the
// security violation aggregator. Assumes a 32-bit register word.
package viol_agg_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SEL_ENA  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Mask with the lowest n bits set.
    function automatic logic [WORD_W-1:0] low_ones(input int n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int k = 0; k < WORD_W; k++) begin
            if (k < n) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/viol_regif.sv
// Module: register port of the aggregator. Decodes a word address and holds
// the enable register. It produces a one-cycle clear vector and muxes read
// data combinationally. Assumes NUM_SRC <= 32 and ADDR_W >= 2.
module viol_regif
    import viol_agg_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [NUM_SRC-1:0] flags,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] clr_vec,
    output logic [WORD_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2);

    reg_sel_e sel;
    logic     wr_ok;
    logic     ena_wr;

    // Translate the word address into a register selector.
    always_comb begin
        if (bus_addr == A_ENA)       sel = SEL_ENA;
        else if (bus_addr == A_STAT) sel = SEL_STAT;
        else if (bus_addr == A_CLR)  sel = SEL_CLR;
        else                         sel = SEL_NONE;
    end

    assign wr_ok  = bus_sel & bus_wr;
    assign ena_wr = wr_ok && (sel == SEL_ENA);

    // Enable register: all sources armed at reset, loaded on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '1;
        else if (ena_wr) en_q <= bus_wdata[NUM_SRC-1:0];
    end

    // Clear vector lasts only for the cycle of the write.
    always_comb begin
        clr_vec = '0;
        if (wr_ok && (sel == SEL_CLR)) clr_vec = bus_wdata[NUM_SRC-1:0];
    end

    // Read mux; unimplemented bits and addresses return zero.
    always_comb begin
        rdata = '0;
        if (bus_sel) begin
            case (sel)
                SEL_ENA:  rdata = WORD_W'(en_q);
                SEL_STAT: rdata = WORD_W'(flags);
                default:  rdata = '0;
            endcase
        end
    end

    // R1
    ena_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (WORD_W'(en_q) == low_ones(NUM_SRC)));

    // R8
    ena_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_wr |=> $stable(en_q));

endmodule

// File: rtl/viol_flag_bank.sv
// Module: one sticky flag per source. An enabled pulse sets the flag and
// the clear vector drops it. Set wins over clear in the same cycle.
// Assumes single-cycle pulses already synchronous to clk.
module viol_flag_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ev,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] flags
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic bit_q;

        // Per-source flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                bit_q <= 1'b0;
            else if (ev[i] && en[i])   bit_q <= 1'b1;
            else if (clr[i])           bit_q <= 1'b0;
        end

        assign flags[i] = bit_q;
    end

    // R3
    no_masked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(ev & en)) == '0));

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flags) & ~$past(clr) & ~flags) == '0));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(ev & en) & ~flags) == '0));

endmodule

// File: rtl/viol_irq_gate.sv
// Module: reduces the flags to one line and gates it with the global
// security enable. Purely combinational; assumes flags come from registers.
module viol_irq_gate #(
    parameter int NUM_SRC = 32
) (
    input  logic               sec_en,
    input  logic [NUM_SRC-1:0] flags,
    output logic               irq
);

    logic any_pending;

    // OR-reduce the pending flags.
    always_comb any_pending = |flags;

    // Hard block while security is disabled.
    always_comb irq = sec_en & any_pending;

endmodule

// File: rtl/secviol_agg.sv
// Module: top of the security violation aggregator. Wires the register
// port, the flag bank and the interrupt gate together. Assumes NUM_SRC in
// 1..32 and ADDR_W >= 2.
module secviol_agg
    import viol_agg_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_en_i,
    input  logic [NUM_SRC-1:0] ev_i,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] flags;

    viol_regif #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel_i),
        .bus_wr   (bus_wr_i),
        .bus_addr (bus_addr_i),
        .bus_wdata(bus_wdata_i),
        .flags    (flags),
        .en_q     (en_q),
        .clr_vec  (clr_vec),
        .rdata    (bus_rdata_o)
    );

    viol_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .ev   (ev_i),
        .en   (en_q),
        .clr  (clr_vec),
        .flags(flags)
    );

    viol_irq_gate #(.NUM_SRC(NUM_SRC)) u_gate (
        .sec_en(sec_en_i),
        .flags (flags),
        .irq   (irq_o)
    );

    // R7
    irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_en_i |-> !irq_o);

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags != '0));

    // R6
    irq_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_en_i && (flags != '0)) |-> irq_o);

endmodule

// File: tb/secviol_agg_bench.sv
// Directed bench for secviol_agg: one task per scenario.
module secviol_agg_bench;

    localparam int NSRC = 20;
    localparam int AW   = 3;
    localparam logic [31:0] ALL = 32'h000F_FFFF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sec_en = 1'b0;
    logic [NSRC-1:0] ev = '0;
    logic            sel = 1'b0;
    logic            wr = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    secviol_agg #(.NUM_SRC(NSRC), .ADDR_W(AW)) u_secviol_agg (
        .clk(clk), .rst_n(rst_n), .sec_en_i(sec_en), .ev_i(ev),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #2 d = rdata;
        sel = 1'b0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        @(negedge clk);
        ev = m;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic clear_all();
        wr_reg(3'd2, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd_reg(3'd0, d); check("R1 enable after reset", d, ALL);
        rd_reg(3'd1, d); check("R1 status after reset", d, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_set_and_sticky();
        logic [31:0] d;
        sec_en = 1'b1;
        pulse(NSRC'(1) << 3);
        #2 check("R6 irq after enabled pulse", {31'b0, irq}, 32'h1);
        rd_reg(3'd1, d); check("R2 status after pulse", d, 32'h8);
        repeat (4) @(negedge clk);
        rd_reg(3'd1, d); check("R4 status held", d, 32'h8);
        wr_reg(3'd2, 32'hFFFF_FFF7);
        rd_reg(3'd1, d); check("R4 zero clear bit ignored", d, 32'h8);
        wr_reg(3'd2, 32'h8);
        rd_reg(3'd1, d); check("R4 cleared by write one", d, 32'h0);
        #1 check("R6 irq drops after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        wr_reg(3'd0, ALL & ~32'h20);
        pulse(NSRC'(32'h60));
        rd_reg(3'd1, d); check("R3 disabled source not flagged", d, 32'h40);
        clear_all();
        wr_reg(3'd0, ALL);
    endtask

    task automatic t_multi_irq();
        logic [31:0] d;
        pulse(NSRC'(32'h0008_0001));
        wr_reg(3'd2, 32'h1);
        #1 check("R6 irq held by remaining flag", {31'b0, irq}, 32'h1);
        rd_reg(3'd1, d); check("R6 remaining flag", d, 32'h0008_0000);
        wr_reg(3'd2, 32'h0008_0000);
        #1 check("R6 irq low after last clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        pulse(NSRC'(32'h40));
        @(negedge clk);
        ev = NSRC'(32'h80);
        sel = 1'b1; wr = 1'b1; addr = 3'd2; wdata = 32'hC0;
        @(negedge clk);
        ev = '0; sel = 1'b0; wr = 1'b0; wdata = '0;
        rd_reg(3'd1, d); check("R5 set wins over clear", d, 32'h80);
        clear_all();
    endtask

    task automatic t_sec_gate();
        logic [31:0] d;
        sec_en = 1'b0;
        pulse(NSRC'(32'h4));
        #2 check("R7 irq blocked", {31'b0, irq}, 32'h0);
        rd_reg(3'd1, d); check("R7 flag latched while blocked", d, 32'h4);
        sec_en = 1'b1;
        #1 check("R7 irq on re-enable", {31'b0, irq}, 32'h1);
        clear_all();
    endtask

    task automatic t_map();
        logic [31:0] d;
        pulse(NSRC'(32'h2));
        wr_reg(3'd1, 32'h0);
        rd_reg(3'd1, d); check("R8 status write ignored", d, 32'h2);
        rd_reg(3'd2, d); check("R8 clear reads zero", d, 32'h0);
        rd_reg(3'd3, d); check("R8 unused addr 3 reads zero", d, 32'h0);
        wr_reg(3'd5, 32'h0);
        rd_reg(3'd5, d); check("R8 unused addr 5 reads zero", d, 32'h0);
        rd_reg(3'd0, d); check("R8 unused write leaves enable", d, ALL);
        @(negedge clk);
        sel = 1'b0; addr = 3'd0;
        #2 check("R8 deselected read zero", rdata, 32'h0);
        clear_all();
    endtask

    task automatic t_upper();
        logic [31:0] d;
        wr_reg(3'd0, 32'hFFFF_FFFF);
        rd_reg(3'd0, d); check("R9 enable upper bits zero", d, ALL);
        wr_reg(3'd0, 32'hFFF0_0000);
        rd_reg(3'd0, d); check("R9 enable upper write dropped", d, 32'h0);
        wr_reg(3'd0, ALL);
        pulse(NSRC'(32'h1));
        wr_reg(3'd2, 32'hFFF0_0000);
        rd_reg(3'd1, d); check("R9 upper clear no effect", d, 32'h1);
        clear_all();
    endtask

    task automatic t_enable_timing();
        logic [31:0] d;
        wr_reg(3'd0, ALL & ~32'h200);
        @(negedge clk);
        ev = NSRC'(32'h200);
        sel = 1'b1; wr = 1'b1; addr = 3'd0; wdata = ALL;
        @(negedge clk);
        ev = '0; sel = 1'b0; wr = 1'b0;
        rd_reg(3'd1, d); check("R10 old enable filters same-edge pulse", d, 32'h0);
        pulse(NSRC'(32'h200));
        rd_reg(3'd1, d); check("R10 new enable active next edge", d, 32'h200);
        clear_all();
        @(negedge clk);
        ev = NSRC'(32'h400);
        sel = 1'b1; wr = 1'b1; addr = 3'd0; wdata = ALL & ~32'h400;
        @(negedge clk);
        ev = '0; sel = 1'b0; wr = 1'b0;
        rd_reg(3'd1, d); check("R10 pulse passes at disabling edge", d, 32'h400);
        clear_all();
        wr_reg(3'd0, ALL);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_and_sticky();
        t_disabled();
        t_multi_irq();
        t_set_wins();
        t_sec_gate();
        t_map();
        t_upper();
        t_enable_timing();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog (R1..R10 run): actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule